// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block collects a vector of level-sensitive interrupt lines from devices and presents one IRQ line to each of a small set of CPUs (four by default). A source has to pass two gates to reach a CPU. The first gate is a single global enable bit per source. The second gate is that CPU's private mask bit for the source. A source whose ID is above the per-CPU range must also be routed to the CPU through the routing field of its own control register. IDs 0 and 1 are kept for the summary lines of the inter-processor doorbell and message-signalled doorbell logic. That logic sits outside the block and drives those two bits of the source vector like any other device.

Software controls the block through a simple register bus that has two windows. The global window holds the identification word, the enable set and clear registers, and one control register per source. The per-CPU window holds the mask set and clear registers and the acknowledge register. A sideband CPU number on the bus picks which CPU's bank a per-CPU access reaches. Software changes enables and masks by writing a source index to a set or clear register, so it never needs a read-modify-write. The acknowledge register gives the lowest-numbered source that is pending for the accessing CPU.

Top module: `mcpu_irq_ctrl`

## Requirements
- R1: After reset every global enable is 0, every per-CPU mask bit is 1 (masked), and every routing field is 0. As a result all `cpuIrq` bits are 0 and every acknowledge read returns 1023.
- R2: A global-window write to offset 0x30 with data equal to a source index enables that source. A write of the same index to offset 0x34 disables it. No other source changes.
- R3: A per-CPU-window write to offset 0x48 masks the indexed source for the CPU named on `busCpu` only. A write to offset 0x4C unmasks it for that CPU only.
- R4: The control register of source s is at global offset 0x100 + 4*s. Bits [NUM_CPU-1:0] are the routing field, where bit c routes the source to CPU c. The field reads back as written, and the higher bits always read 0.
- R5: A global read of offset 0x00 returns NUM_SRC in bits [11:2] and 0 in every other bit.
- R6: A shared source (ID above 28) asserts CPU c only while its line is high, it is globally enabled, routing bit c is set, and it is unmasked for c.
- R7: A per-CPU source (ID 28 or below) ignores its routing field. It asserts CPU c while its line is high, it is globally enabled, and it is unmasked for c.
- R8: `cpuIrq[c]` is the OR over all sources that pass every gate for CPU c. It follows `srcLevel` with no register delay.
- R9: A per-CPU-window read of offset 0x44 returns, in bits [9:0], the lowest-numbered source that passes every gate for `busCpu`. It returns 1023 when no source passes. Bits [31:10] read 0, and the read changes no state.
- R10: Set and clear writes whose 32-bit data is NUM_SRC or larger change no enable and no mask. This holds even when the low bits of the data alias a valid index.
- R11: Read data appears on `busRdata` at the first clock edge after the cycle in which `busRdEn` is high, and it holds that value until the next read. Writes take effect at the edge that samples them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busPerCpu | input | 1 | 1 selects the per-CPU window, 0 selects the global window |
| busCpu | input | CPU_W (2) | Number of the CPU making the access |
| busAddr | input | ADDR_W (12) | Byte offset within the selected window |
| busWdata | input | 32 | Write data (a source index, or a routing field) |
| busRdata | output | 32 | Registered read data |
| srcLevel | input | NUM_SRC (64) | Level-sensitive interrupt lines, bit s is source s |
| cpuIrq | output | NUM_CPU (4) | One interrupt request per CPU |

## Verification
Every state change is a single register update at the edge that samples the write. `cpuIrq` is a combinational function of that state and `srcLevel`. The bench therefore drives writes and source levels on the falling edge and samples the interrupt lines a nanosecond after that falling edge. This is one edge after a write, and in the same half cycle for a change of source level. Read data is registered. Each read holds `busRdEn` for one cycle and samples `busRdata` at the following falling edge, which lies just after the edge that loaded it. A bench model of enables, masks and routing, updated on each write, supplies the expected IRQ vector and the expected acknowledge ID for every CPU after every step.

// File: rtl/mcpu_irq_pkg.sv
package mcpu_irq_pkg;

  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_PENDING = 10'h3FF;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_IDENT = 2'd1,
    RD_ROUTE = 2'd2,
    RD_ACK   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic            setEn;
    logic            clrEn;
    logic            setMask;
    logic            clrMask;
    logic            routeWr;
    logic            rdStb;
    rdSel_e          rdSel;
    logic [ID_W-1:0] idx;
  } ctrlStb_t;

endpackage

// File: rtl/mcpu_irq_decode.sv
module mcpu_irq_decode
  import mcpu_irq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              busPerCpu,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output ctrlStb_t          stb
);

  localparam logic [ADDR_W-1:0] OFF_IDENT   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_ENSET   = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] OFF_ENCLR   = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] OFF_ACK     = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] OFF_MASKSET = ADDR_W'('h48);
  localparam logic [ADDR_W-1:0] OFF_MASKCLR = ADDR_W'('h4C);
  localparam logic [31:0]       ROUTE_BASE  = 32'h100;
  localparam logic [31:0]       ROUTE_END   = ROUTE_BASE + 32'(4 * NUM_SRC);

  logic idxOk;
  logic routeHit;
  logic globalWr;
  logic localWr;

  always_comb begin
    idxOk    = busWdata < 32'(NUM_SRC);
    routeHit = !busPerCpu && (32'(busAddr) >= ROUTE_BASE) &&
               (32'(busAddr) < ROUTE_END) && (busAddr[1:0] == 2'b00);
    globalWr = busWrEn && !busPerCpu;
    localWr  = busWrEn && busPerCpu;

    stb         = '0;
    stb.setEn   = globalWr && (busAddr == OFF_ENSET) && idxOk;
    stb.clrEn   = globalWr && (busAddr == OFF_ENCLR) && idxOk;
    stb.setMask = localWr && (busAddr == OFF_MASKSET) && idxOk;
    stb.clrMask = localWr && (busAddr == OFF_MASKCLR) && idxOk;
    stb.routeWr = busWrEn && routeHit;
    stb.rdStb   = busRdEn;
    stb.idx     = routeHit ? ID_W'((32'(busAddr) - ROUTE_BASE) >> 2)
                           : ID_W'(busWdata);

    if (!busPerCpu && busAddr == OFF_IDENT)   stb.rdSel = RD_IDENT;
    else if (routeHit)                        stb.rdSel = RD_ROUTE;
    else if (busPerCpu && busAddr == OFF_ACK) stb.rdSel = RD_ACK;
    else                                      stb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/mcpu_irq_core.sv
module mcpu_irq_core
  import mcpu_irq_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CPU   = 4,
  parameter int PCPU_LAST = 28,
  parameter int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [CPU_W-1:0]   busCpu,
  input  logic [NUM_CPU-1:0] routeData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [NUM_CPU-1:0] cpuIrq,
  output logic [31:0]        busRdata
);

  localparam logic [31:0] IDENT_WORD = 32'(NUM_SRC) << 2;

  logic [NUM_SRC-1:0]                enQ;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]   maskQ;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]   routeQ;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]   live;
  logic [NUM_CPU-1:0][ID_W-1:0]      ackId;
  logic [NUM_SRC-1:0]                idxHit;
  logic [NUM_CPU-1:0]                cpuHit;
  logic [NUM_CPU-1:0]                routeSel;
  logic [ID_W-1:0]                   ackSel;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_idx
    assign idxHit[s] = (stb.idx == ID_W'(s));
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign cpuHit[c] = (busCpu == CPU_W'(c));
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
      if (s <= PCPU_LAST) begin : g_private
        assign live[c][s] = srcLevel[s] && enQ[s] && !maskQ[c][s];
      end else begin : g_shared
        assign live[c][s] = srcLevel[s] && enQ[s] && !maskQ[c][s] && routeQ[s][c];
      end
    end
    assign cpuIrq[c] = |live[c];

    always_comb begin
      ackId[c] = NO_PENDING;
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
        if (live[c][s]) ackId[c] = ID_W'(s);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= '0;
      maskQ  <= '1;
      routeQ <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (idxHit[s]) begin
          if (stb.setEn)        enQ[s] <= 1'b1;
          else if (stb.clrEn)   enQ[s] <= 1'b0;
          if (stb.routeWr)      routeQ[s] <= routeData;
          for (int c = 0; c < NUM_CPU; c++) begin
            if (cpuHit[c]) begin
              if (stb.setMask)      maskQ[c][s] <= 1'b1;
              else if (stb.clrMask) maskQ[c][s] <= 1'b0;
            end
          end
        end
      end
    end
  end

  always_comb begin
    routeSel = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (idxHit[s]) routeSel = routeQ[s];
    end
    ackSel = NO_PENDING;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpuHit[c]) ackSel = ackId[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rdStb) begin
      case (stb.rdSel)
        RD_IDENT: busRdata <= IDENT_WORD;
        RD_ROUTE: busRdata <= 32'(routeSel);
        RD_ACK:   busRdata <= 32'(ackSel);
        default:  busRdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mcpu_irq_ctrl.sv
module mcpu_irq_ctrl
  import mcpu_irq_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CPU   = 4,
  parameter int PCPU_LAST = 28,
  parameter int ADDR_W    = 12,
  parameter int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic               busPerCpu,
  input  logic [CPU_W-1:0]   busCpu,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [NUM_CPU-1:0] cpuIrq
);

  ctrlStb_t stb;

  mcpu_irq_decode #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busPerCpu (busPerCpu),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .stb       (stb)
  );

  mcpu_irq_core #(
    .NUM_SRC   (NUM_SRC),
    .NUM_CPU   (NUM_CPU),
    .PCPU_LAST (PCPU_LAST),
    .CPU_W     (CPU_W)
  ) u_core (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busCpu    (busCpu),
    .routeData (busWdata[NUM_CPU-1:0]),
    .srcLevel  (srcLevel),
    .cpuIrq    (cpuIrq),
    .busRdata  (busRdata)
  );

endmodule

// File: rtl/mcpu_irq_ctrl_chk.sv
module mcpu_irq_ctrl_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int CPU_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               busRdEn,
  input logic               busPerCpu,
  input logic [CPU_W-1:0]   busCpu,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busRdata,
  input logic [NUM_SRC-1:0] srcLevel,
  input logic [NUM_CPU-1:0] cpuIrq
);

  logic identRd;
  logic ackRd;
  logic routeRd;
  logic irqOfCpu;

  always_comb begin
    identRd  = busRdEn && !busPerCpu && (busAddr == '0);
    ackRd    = busRdEn && busPerCpu && (32'(busAddr) == 32'h44) && (32'(busCpu) < NUM_CPU);
    routeRd  = busRdEn && !busPerCpu && (32'(busAddr) >= 32'h100) &&
               (32'(busAddr) < 32'h100 + 32'(4 * NUM_SRC)) && (busAddr[1:0] == 2'b00);
    irqOfCpu = 1'b0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (busCpu == CPU_W'(c)) irqOfCpu = cpuIrq[c];
    end
  end

  p_ident_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    identRd |=> busRdata == (32'(NUM_SRC) << 2));

  p_ack_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackRd |=> (busRdata[31:10] == '0) &&
              ((32'(busRdata[9:0]) < NUM_SRC) || (busRdata[9:0] == 10'h3FF)));

  p_ack_matches_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackRd |=> ((busRdata[9:0] == 10'h3FF) == !$past(irqOfCpu)));

  p_quiet_lines_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srcLevel == '0) |-> (cpuIrq == '0));

  p_route_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    routeRd |=> (busRdata[31:NUM_CPU] == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdata));

endmodule

bind mcpu_irq_ctrl mcpu_irq_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_CPU (NUM_CPU),
  .ADDR_W  (ADDR_W),
  .CPU_W   (CPU_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busRdEn   (busRdEn),
  .busPerCpu (busPerCpu),
  .busCpu    (busCpu),
  .busAddr   (busAddr),
  .busRdata  (busRdata),
  .srcLevel  (srcLevel),
  .cpuIrq    (cpuIrq)
);

// File: tb/mcpu_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mcpu_irq_ctrl_bench;

  localparam int NS = 64;
  localparam int NC = 4;
  localparam int PL = 28;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0;
  logic          busRdEn = 1'b0;
  logic          busPerCpu = 1'b0;
  logic [1:0]    busCpu = '0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NS-1:0] srcLevel = '0;
  logic [NC-1:0] cpuIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic          mEn [NS];
  logic          mMask [NC][NS];
  logic [NC-1:0] mRoute [NS];

  always #4 clk = ~clk;

  mcpu_irq_ctrl u_mcpu_irq_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busPerCpu(busPerCpu), .busCpu(busCpu), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcLevel(srcLevel), .cpuIrq(cpuIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(bit win, int cpu, int addr, logic [31:0] data);
    @(negedge clk);
    busPerCpu = win; busCpu = 2'(cpu); busAddr = 12'(addr); busWdata = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(bit win, int cpu, int addr, output logic [31:0] data);
    @(negedge clk);
    busPerCpu = win; busCpu = 2'(cpu); busAddr = 12'(addr); busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    data = busRdata;
  endtask

  // Model-updating helpers; indices >= NS leave the model untouched (R10).
  task automatic enSet(int idx);
    busWrite(0, 0, 'h30, 32'(idx));
    if (idx < NS) mEn[idx] = 1'b1;
  endtask
  task automatic enClr(int idx);
    busWrite(0, 0, 'h34, 32'(idx));
    if (idx < NS) mEn[idx] = 1'b0;
  endtask
  task automatic maskSet(int cpu, int idx);
    busWrite(1, cpu, 'h48, 32'(idx));
    if (idx < NS) mMask[cpu][idx] = 1'b1;
  endtask
  task automatic maskClr(int cpu, int idx);
    busWrite(1, cpu, 'h4C, 32'(idx));
    if (idx < NS) mMask[cpu][idx] = 1'b0;
  endtask
  task automatic routeSet(int s, logic [31:0] data);
    busWrite(0, 0, 'h100 + 4 * s, data);
    mRoute[s] = data[NC-1:0];
  endtask

  function automatic logic liveM(int c, int s);
    return srcLevel[s] && mEn[s] && !mMask[c][s] && (s <= PL || mRoute[s][c]);
  endfunction

  function automatic logic [NC-1:0] expIrq();
    logic [NC-1:0] v = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (liveM(c, s)) v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] expAck(int c);
    for (int s = 0; s < NS; s++)
      if (liveM(c, s)) return 32'(s);
    return 32'd1023;
  endfunction

  task automatic checkState(string req);
    logic [31:0] rd;
    #1;
    check({req, "/R8 irq"}, 32'(cpuIrq), 32'(expIrq()));
    for (int c = 0; c < NC; c++) begin
      busRead(1, c, 'h44, rd);
      check({req, "/R9 ack"}, rd, expAck(c));
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    for (int s = 0; s < NS; s++) begin
      mEn[s] = 1'b0; mRoute[s] = '0;
      for (int c = 0; c < NC; c++) mMask[c][s] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, with every line high
    srcLevel = '1;
    checkState("R1");
    busRead(0, 0, 'h100 + 4 * 40, rd);
    check("R1 route", rd, 32'd0);

    // R5: identification word
    busRead(0, 0, 'h00, rd);
    check("R5 ident", rd, 32'(NS) << 2);

    // R3: unmask everything on every CPU; still nothing enabled
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) maskClr(c, s);
    checkState("R3 unmasked");

    // R2, R7, R6: one source enabled at a time, routing all zero
    for (int s = 0; s < NS; s++) begin
      enSet(s);
      #1;
      check(s <= PL ? "R7 private reaches all" : "R6 unrouted shared",
            32'(cpuIrq), s <= PL ? 32'hF : 32'h0);
      busRead(1, s % NC, 'h44, rd);
      check("R2 ack single", rd, s <= PL ? 32'(s) : 32'd1023);
      enClr(s);
      #1;
      check("R2 cleared", 32'(cpuIrq), 32'h0);
    end

    // R4, R6: routing sweep on shared sources, R7 private ignores routing
    foreach (mRoute[i]) if (i == 29 || i == 45 || i == 63) begin
      enSet(i);
      for (int r = 0; r < 16; r++) begin
        routeSet(i, 32'hFFFF_FFF0 | 32'(r));
        #1;
        check("R6 routed irq", 32'(cpuIrq), 32'(r));
        busRead(0, 0, 'h100 + 4 * i, rd);
        check("R4 readback", rd, 32'(r));
      end
      routeSet(i, 32'h0);
      enClr(i);
    end
    enSet(3);
    routeSet(3, 32'h1);
    checkState("R7 route ignored");

    // R3: masks are per CPU
    for (int c = 0; c < NC; c++) begin
      maskSet(c, 3);
      #1;
      check("R3 mask one cpu", 32'(cpuIrq), 32'hF & ~((32'h1 << (c + 1)) - 1));
    end
    for (int c = 0; c < NC; c++) maskClr(c, 3);
    checkState("R3 unmask");

    // R10: out-of-range indices that alias source 3 or 5
    enSet(NS + 5);
    checkState("R10 set-enable ignored");
    enClr(NS + 3);
    maskSet(1, NS + 3);
    maskSet(2, 1024 + 3);
    checkState("R10 clear/mask ignored");
    enClr(3);

    // R8, R11: lines act without a register delay; read data holds
    enSet(50); routeSet(50, 32'h4);
    srcLevel = '0;
    #1 check("R8 line low", 32'(cpuIrq), 32'h0);
    @(negedge clk); srcLevel[50] = 1'b1;
    #1 check("R8 line high", 32'(cpuIrq), 32'h4);
    busRead(1, 2, 'h44, rd);
    check("R11 ack timing", rd, 32'd50);
    held = rd;
    enClr(50);
    repeat (3) @(negedge clk);
    check("R11 rdata hold", busRdata, held);

    // R9: random traffic, priority checked against the model
    for (int it = 0; it < 150; it++) begin
      for (int k = 0; k < 3; k++) begin
        int idx = $urandom % (NS + 6);
        int cpu = $urandom % NC;
        case ($urandom % 5)
          0: enSet(idx);
          1: enClr(idx);
          2: maskSet(cpu, idx);
          3: maskClr(cpu, idx);
          default: routeSet(idx % NS, $urandom);
        endcase
      end
      @(negedge clk);
      srcLevel = {$urandom, $urandom};
      checkState("R9 random");
    end

    finishRun();
  end

endmodule